// File: doc/BRIEF.md
# Write-Once Watchdog Timer

This block is a watchdog timer clocked by a slow clock. A fixed prescaler divides that clock to produce decrement ticks for a 12-bit down-counter. Software must restart the counter before it runs out. If it does not, the block reports a fault. A fault is either a one-cycle reset request (system-wide or processor-only) or a level interrupt. Which one depends on the operating mode.

The operating mode lives in a single 32-bit register. It accepts one write after reset and then locks. Out of reset the watchdog already runs, using default settings that request a system reset. Software can make exactly one change: set its own reload and window values, choose the fault action, freeze the counter during idle or debug halt, or stop the watchdog for good.

A restart is a keyed write to the command register. It reloads the counter at once. A restart made too early, while the counter is still above the window value, counts as a fault. The two fault causes are kept in sticky flags. Reading them clears them.

Top module: `wdog_once`

## Requirements
- R1: After reset the mode reads 32'h02FF_FFFF (reload 0xFFF, window 0xFFF, reset enable set, all other bits clear), the flags read 0, all fault outputs are low, and the counter starts at 0xFFF and counts down at once.
- R2: Register map: address 0 is the command register, 1 is mode, 2 is flags, 3 is a read-only counter value. Mode bits are: [11:0] reload, [23:12] window, 24 interrupt enable, 25 reset enable, 26 processor-only reset, 27 stop, 28 freeze-on-idle, 29 freeze-on-debug-halt. Only the first mode write after reset takes effect. Later writes leave the mode unchanged.
- R3: A command write with 0xA5 in bits [31:24] and bit 0 set reloads the counter from the reload field in that same cycle and clears the prescaler. A write with any other key changes nothing.
- R4: While running, the counter drops by one every PRESCALE clock cycles.
- R5: A tick that would bring the counter to zero is an underflow. It sets flag bit 0 and reloads the counter. If reset enable is set and processor-only is clear, it also raises `rst_req` for exactly one cycle, in the cycle after the event edge.
- R6: `fault_irq` is high exactly while interrupt enable is set and at least one flag is set.
- R7: With reset enable and processor-only both set, a fault raises `proc_rst_req` for one cycle instead of `rst_req`. The two requests are never high together.
- R8: A read of address 2 returns the flags and clears them at that clock edge.
- R9: A valid restart while the counter is above the window field sets flag bit 1 and causes a fault. A valid restart at or below the window field does not.
- R10: Once the stop bit is written, the counter holds, restarts are ignored, no fault is raised, and the bit cannot be cleared before reset.
- R11: While `sys_idle` is high with freeze-on-idle set, or `dbg_halt` is high with freeze-on-debug-halt set, the counter and prescaler hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Active-low power reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears flags when reading address 2) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| sys_idle | input | 1 | System idle indication |
| dbg_halt | input | 1 | Processor halted by debugger |
| rst_req | output | 1 | One-cycle system reset request |
| proc_rst_req | output | 1 | One-cycle processor-only reset request |
| fault_irq | output | 1 | Fault interrupt, level |

## Verification
The hardest case to reach is the window error. The mode register can be written only once, so a single mode setting must cover both the early restart and the in-window restart. The counter must also be caught inside a narrow band of values. Each scenario therefore starts with its own reset and one mode write. The bench then issues the first restart while the counter is still near 0xFFF, which is well above the window, and counts exactly 33 clocks so that the second restart falls where the counter equals the window value. The stop and freeze cases are checked at the ports: the counter is read back before and after long waits and after a keyed restart.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int CNT_W = 12;
   localparam int RSV_W = 32 - 2*CNT_W - 6;

   typedef enum logic [1:0] {
      A_CMD  = 2'd0,
      A_MODE = 2'd1,
      A_FLAG = 2'd2,
      A_CNT  = 2'd3
   } addr_e;

   typedef struct packed {
      logic [RSV_W-1:0] rsv;
      logic             dbg_frz;
      logic             idle_frz;
      logic             stop;
      logic             proc_only;
      logic             rst_en;
      logic             irq_en;
      logic [CNT_W-1:0] window;
      logic [CNT_W-1:0] reload;
   } mode_t;

   localparam mode_t MODE_DEF = '{
      rsv:       '0,
      dbg_frz:   1'b0,
      idle_frz:  1'b0,
      stop:      1'b0,
      proc_only: 1'b0,
      rst_en:    1'b1,
      irq_en:    1'b0,
      window:    {CNT_W{1'b1}},
      reload:    {CNT_W{1'b1}}
   };
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
   parameter int PRESCALE = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);
   localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
   localparam bit POW2 = ((PRESCALE & (PRESCALE - 1)) == 0);

   logic [PW-1:0] pre_q;

   generate
      if (POW2) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pre_q <= '0;
            else if (clr) pre_q <= '0;
            else if (run) pre_q <= pre_q + 1'b1;
         end
         assign tick = run && (&pre_q);
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pre_q <= '0;
            else if (clr) pre_q <= '0;
            else if (run) pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
         end
         assign tick = run && (pre_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdog_count.sv
module wdog_count
   import wdog_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic [CNT_W-1:0] reload,
   input  logic [CNT_W-1:0] window,
   output logic [CNT_W-1:0] cnt,
   output logic             unf_evt,
   output logic             err_evt
);
   logic [CNT_W-1:0] cnt_q;

   assign unf_evt = tick && !restart && (cnt_q <= CNT_W'(1));
   assign err_evt = restart && (cnt_q > window);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= MODE_DEF.reload;
      else if (restart) cnt_q <= reload;
      else if (unf_evt) cnt_q <= reload;
      else if (tick)    cnt_q <= cnt_q - 1'b1;
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter logic [7:0] KEY = 8'hA5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [1:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic [CNT_W-1:0] cnt,
   input  logic             unf_evt,
   input  logic             err_evt,
   output mode_t            mode_q,
   output logic             locked,
   output logic             restart_ok,
   output logic             rst_req,
   output logic             proc_rst_req,
   output logic             fault_irq
);
   logic  unf_f, err_f, fault, flag_rd, mode_wr;
   addr_e addr;

   assign addr       = addr_e'(bus_addr);
   assign mode_wr    = bus_wr && (addr == A_MODE) && !locked;
   assign flag_rd    = bus_rd && (addr == A_FLAG);
   assign restart_ok = bus_wr && (addr == A_CMD) && (bus_wdata[31:24] == KEY)
                       && bus_wdata[0] && !mode_q.stop;
   assign fault      = unf_evt || err_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_DEF;
         locked <= 1'b0;
      end else if (mode_wr) begin
         mode_q <= mode_t'(bus_wdata);
         locked <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unf_f        <= 1'b0;
         err_f        <= 1'b0;
         rst_req      <= 1'b0;
         proc_rst_req <= 1'b0;
      end else begin
         unf_f        <= unf_evt || (unf_f && !flag_rd);
         err_f        <= err_evt || (err_f && !flag_rd);
         rst_req      <= fault && mode_q.rst_en && !mode_q.proc_only;
         proc_rst_req <= fault && mode_q.rst_en && mode_q.proc_only;
      end
   end

   assign fault_irq = mode_q.irq_en && (unf_f || err_f);

   always_comb begin
      case (addr)
         A_MODE:  bus_rdata = mode_q;
         A_FLAG:  bus_rdata = {30'd0, err_f, unf_f};
         A_CNT:   bus_rdata = 32'(cnt);
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdog_once.sv
module wdog_once
   import wdog_pkg::*;
#(
   parameter int         PRESCALE = 128,
   parameter logic [7:0] KEY      = 8'hA5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [1:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        sys_idle,
   input  logic        dbg_halt,
   output logic        rst_req,
   output logic        proc_rst_req,
   output logic        fault_irq
);
   generate
      if (PRESCALE < 2) begin : g_bad_pre
         $error("PRESCALE must be at least 2");
      end
      if (RSV_W < 0) begin : g_bad_w
         $error("counter too wide for mode register");
      end
   endgenerate

   mode_t            mode_q;
   logic             locked, restart_ok, tick, run, freeze, unf_evt, err_evt;
   logic [CNT_W-1:0] cnt;

   assign freeze = (sys_idle && mode_q.idle_frz) || (dbg_halt && mode_q.dbg_frz);
   assign run    = !mode_q.stop && !freeze;

   wdog_regs #(.KEY(KEY)) u_regs (
      .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
      .cnt, .unf_evt, .err_evt, .mode_q, .locked, .restart_ok,
      .rst_req, .proc_rst_req, .fault_irq
   );

   wdog_prescale #(.PRESCALE(PRESCALE)) u_pre (
      .clk, .rst_n, .run, .clr(restart_ok), .tick
   );

   wdog_count u_cnt (
      .clk, .rst_n, .tick, .restart(restart_ok),
      .reload(mode_q.reload), .window(mode_q.window),
      .cnt, .unf_evt, .err_evt
   );
endmodule

// File: rtl/wdog_once_chk.sv
module wdog_once_chk
   import wdog_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             rst_req,
   input logic             proc_rst_req,
   input logic             fault_irq,
   input mode_t            mode_q,
   input logic             locked,
   input logic             freeze,
   input logic             restart_ok,
   input logic [CNT_W-1:0] cnt
);
   AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_req && proc_rst_req)); // R7
   AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(mode_q)); // R2
   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q.stop |=> (mode_q.stop && $stable(cnt))); // R10
   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q.stop && $past(mode_q.stop)) |-> (!rst_req && !proc_rst_req)); // R10
   AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !restart_ok) |=> $stable(cnt)); // R11
   AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_irq |-> mode_q.irq_en); // R6
endmodule

bind wdog_once wdog_once_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .proc_rst_req(proc_rst_req),
   .fault_irq(fault_irq), .mode_q(mode_q), .locked(locked), .freeze(freeze),
   .restart_ok(restart_ok), .cnt(cnt)
);

// File: tb/tb_wdog_once.sv
module tb_wdog_once;
   logic        clk = 0, rst_n = 0;
   logic        bus_wr = 0, bus_rd = 0;
   logic [1:0]  bus_addr = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic        sys_idle = 0, dbg_halt = 0;
   logic        rst_req, proc_rst_req, fault_irq;
   int checks = 0, fails = 0, rst_cnt = 0, proc_cnt = 0;
   logic [31:0] v, a;

   always #10 clk = ~clk;

   wdog_once #(.PRESCALE(4)) dut (.*);

   always @(negedge clk) begin
      if (rst_req) rst_cnt++;
      if (proc_rst_req) proc_cnt++;
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(int rl, int win, bit irq, bit rst, bit po,
                                      bit stp, bit idl, bit dbg);
      return {2'b00, dbg, idl, stp, po, rst, irq, 12'(win), 12'(rl)};
   endfunction

   task automatic do_reset();
      rst_n = 0; sys_idle = 0; dbg_halt = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      rst_cnt = 0; proc_cnt = 0;
   endtask

   task automatic wr(logic [1:0] ad, logic [31:0] d);
      bus_wr = 1; bus_addr = ad; bus_wdata = d;
      @(posedge clk);
      @(negedge clk) bus_wr = 0;
   endtask

   task automatic rd(logic [1:0] ad, output logic [31:0] d);
      bus_rd = 1; bus_addr = ad;
      #1 d = bus_rdata;
      @(posedge clk);
      @(negedge clk) bus_rd = 0;
   endtask

   task automatic kick(logic [7:0] key);
      wr(2'd0, {key, 23'd0, 1'b1});
   endtask

   task automatic t_reset();
      do_reset();
      rd(2'd3, v); chk("R1 counter", v, 32'hFFF);
      rd(2'd1, v); chk("R1 mode", v, 32'h02FF_FFFF);
      rd(2'd2, v); chk("R1 flags", v, 0);
      chk("R1 outputs", {rst_req, proc_rst_req, fault_irq}, 0);
      @(posedge clk); @(negedge clk);
      rd(2'd3, v); chk("R1 R4 counting", v, 32'hFFE);
   endtask

   task automatic t_lock();
      do_reset();
      wr(2'd1, mk(5, 100, 1, 0, 0, 0, 0, 0));
      wr(2'd1, mk(9, 7, 0, 1, 1, 0, 0, 0));
      rd(2'd1, v); chk("R2 write once", v, mk(5, 100, 1, 0, 0, 0, 0, 0));
   endtask

   task automatic t_key();
      do_reset();
      wr(2'd1, mk(50, 4095, 0, 1, 0, 0, 0, 0));
      kick(8'hA5);
      rd(2'd3, v); chk("R3 reload", v, 50);
      repeat (7) @(posedge clk); @(negedge clk);
      rd(2'd3, v); chk("R4 rate", v, 48);
      kick(8'h5A);
      rd(2'd3, v); chk("R3 wrong key", v, 48);
      kick(8'hA5);
      rd(2'd3, v); chk("R3 good key", v, 50);
   endtask

   task automatic t_unf();
      do_reset();
      wr(2'd1, mk(3, 4095, 0, 1, 0, 0, 0, 0));
      kick(8'hA5);
      repeat (11) @(posedge clk); @(negedge clk);
      chk("R5 no early req", rst_req, 0);
      @(posedge clk); @(negedge clk);
      chk("R5 req", rst_req, 1);
      rd(2'd2, v); chk("R5 flag", v, 1);
      chk("R5 one cycle", rst_req, 0);
      rd(2'd2, v); chk("R8 cleared", v, 0);
      rd(2'd3, v); chk("R5 reloaded", v, 3);
      chk("R5 count", rst_cnt, 1);
   endtask

   task automatic t_irq();
      do_reset();
      wr(2'd1, mk(2, 4095, 1, 0, 0, 0, 0, 0));
      kick(8'hA5);
      repeat (8) @(posedge clk); @(negedge clk);
      chk("R6 irq set", fault_irq, 1);
      chk("R6 no reset", rst_req, 0);
      rd(2'd2, v);
      chk("R8 irq cleared", fault_irq, 0);
   endtask

   task automatic t_proc();
      do_reset();
      wr(2'd1, mk(2, 4095, 0, 1, 1, 0, 0, 0));
      kick(8'hA5);
      repeat (8) @(posedge clk); @(negedge clk);
      chk("R7 proc req", {proc_rst_req, rst_req}, 2'b10);
      repeat (2) @(posedge clk); @(negedge clk);
      chk("R7 counts", {32'(proc_cnt), 32'(rst_cnt)} == {32'd1, 32'd0}, 1);
   endtask

   task automatic t_window();
      do_reset();
      wr(2'd1, mk(10, 2, 0, 1, 0, 0, 0, 0));
      kick(8'hA5);
      chk("R9 early fault", rst_req, 1);
      rd(2'd2, v); chk("R9 err flag", v, 2);
      rd(2'd3, v); chk("R9 reloaded", v, 10);
      repeat (31) @(posedge clk); @(negedge clk);
      rd(2'd3, v); chk("R9 at window", v, 2);
      kick(8'hA5);
      rd(2'd2, v); chk("R9 in window ok", v, 0);
      chk("R9 one fault", rst_cnt, 1);
   endtask

   task automatic t_stop();
      do_reset();
      wr(2'd1, mk(5, 4095, 0, 1, 0, 1, 0, 0));
      rd(2'd3, a);
      repeat (40) @(posedge clk); @(negedge clk);
      rd(2'd3, v); chk("R10 held", v, a);
      kick(8'hA5);
      rd(2'd3, v); chk("R10 restart ignored", v, a);
      wr(2'd1, mk(5, 4095, 0, 1, 0, 0, 0, 0));
      rd(2'd1, v); chk("R10 sticky", v[27], 1);
      chk("R10 no fault", rst_cnt + proc_cnt, 0);
   endtask

   task automatic t_freeze();
      do_reset();
      wr(2'd1, mk(100, 4095, 0, 1, 0, 0, 1, 1));
      sys_idle = 1;
      kick(8'hA5);
      repeat (20) @(posedge clk); @(negedge clk);
      rd(2'd3, v); chk("R11 idle freeze", v, 100);
      sys_idle = 0;
      repeat (4) @(posedge clk); @(negedge clk);
      rd(2'd3, v); chk("R11 resumes", v, 99);
      dbg_halt = 1;
      repeat (20) @(posedge clk); @(negedge clk);
      rd(2'd3, v); chk("R11 debug freeze", v, 99);
      dbg_halt = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_lock();
      t_key();
      t_unf();
      t_irq();
      t_proc();
      t_window();
      t_stop();
      t_freeze();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule